// File: doc/BRIEF.md
# Flash Converter Digital Back End

This block is the digital half of an 8-bit parallel-comparator converter that also reports overflow. It receives the raw outputs of a row of 256 comparators as a thermometer word. It holds that word in two latch rows, one clocked on each clock edge. It reduces the held word to a 9-bit result, made of an overflow flag and an 8-bit count, and loads that result into an output register. A conversion therefore spans two clock edges of the same polarity.

A polarity input can complement the clock as it enters the block, which swaps the role of every edge. Two enable inputs control the output drivers, which are modelled as a value plus a per-bit drive enable. One enable acts as a master switch for all nine outputs. The other turns off only the eight count bits and leaves the overflow flag driven. Because the flag stays driven on its own, two such blocks can be stacked into a 9-bit converter: the overflow flag of one selects which block drives a shared data bus.

The count is the number of set bits in the lower 255 comparator inputs. A word with a bubble (a non-monotonic word) still gives a defined result.

Top module: `flash_backend`

## Requirements
- R1: When comparator input 256 (`therm[255]`) is clear, `code` equals the number of set bits in `therm[254:0]`. `therm[i]` is comparator i+1, and `code[0]` is the least significant bit. A word with bubbles is counted the same way, so bits 0..9 plus bit 20 set gives 11.
- R2: When `therm[255]` is set, `ovf` is 1 and `code` is 8'hFF, whatever the other bits are. This reads as 511 in the form {ovf, code}. When `therm[255]` is clear, `ovf` is 0, so all of the lower 255 bits set gives {ovf, code} = 255.
- R3: With `clk_invert`=0, a word present at a falling clock edge appears on the outputs just after the next falling edge. Words applied on consecutive cycles come out on consecutive cycles.
- R4: With `clk_invert`=1, every edge role swaps, so the outputs update just after a rising clock edge and hold across falling edges.
- R5: The outputs change only at update edges. They hold their value across the opposite edge of the clock.
- R6: With `out_en`=1 and `data_off`=0, `code_oe` is 8'hFF and `ovf_oe` is 1.
- R7: With `out_en`=1 and `data_off`=1, `code_oe` is 0. `ovf_oe` stays 1 and `ovf` still carries the true overflow value.
- R8: With `out_en`=0, `code_oe` is 0 and `ovf_oe` is 0, whatever `data_off` is.
- R9: Driving `rst_n` low clears both latch rows and the output register to zero at once, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Conversion clock; both edges are used |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_invert | input | 1 | 1 complements the clock as it enters the block |
| therm | input | 256 | Comparator outputs; bit i is comparator i+1 |
| out_en | input | 1 | Master drive enable, active high |
| data_off | input | 1 | 1 turns off the drivers of the count bits only |
| code | output | 8 | Registered count value |
| ovf | output | 1 | Registered overflow flag |
| code_oe | output | 8 | Per-bit drive enables for `code` |
| ovf_oe | output | 1 | Drive enable for `ovf` |

## Verification
Two functions can act in the same cycle: the output register taking a new result, and the driver enables changing. The bench provokes this by loading an overflow word while `data_off` is set. It then requires the flag to come out driven and correct while every count bit stays undriven. It also checks that the value behind the undriven count bits is still 8'hFF, so that releasing `data_off` exposes it at once. A second case of the same kind starts a new word on the input in the very cycle that the previous word is reaching the output register. That case is judged by the exact cycle in which each output value appears.

// File: rtl/flash_backend.sv
module flash_backend #(
  parameter int NCMP = 256
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      clk_invert,
  input  logic [NCMP-1:0]           therm,
  input  logic                      out_en,
  input  logic                      data_off,
  output logic [$clog2(NCMP)-1:0]   code,
  output logic                      ovf,
  output logic [$clog2(NCMP)-1:0]   code_oe,
  output logic                      ovf_oe
);
  localparam int CW = $clog2(NCMP);

  logic            eclk;
  logic [NCMP-1:0] row1, row2;
  logic [CW-1:0]   code_q, dec_code;
  logic            ovf_q, dec_ovf;

  assign eclk = clk ^ clk_invert;

  function automatic logic [CW-1:0] ones_count(input logic [NCMP-2:0] w);
    logic [CW-1:0] c;
    c = '0;
    for (int i = 0; i < NCMP-1; i++) c = c + CW'(w[i]);
    return c;
  endfunction

  assign dec_ovf  = row2[NCMP-1];
  assign dec_code = dec_ovf ? '1 : ones_count(row2[NCMP-2:0]);

  always_ff @(negedge eclk or negedge rst_n)
    if (!rst_n) begin
      row1   <= '0;
      code_q <= '0;
      ovf_q  <= 1'b0;
    end else begin
      row1   <= therm;
      code_q <= dec_code;
      ovf_q  <= dec_ovf;
    end

  always_ff @(posedge eclk or negedge rst_n)
    if (!rst_n) row2 <= '0;
    else        row2 <= row1;

  assign code    = code_q;
  assign ovf     = ovf_q;
  assign ovf_oe  = out_en;
  assign code_oe = {CW{out_en & ~data_off}};

  // R2
  ovf_ones_chk: assert property (@(posedge eclk) disable iff (!rst_n)
    ovf |-> (&code));

  // R3
  row_pass_chk: assert property (@(posedge eclk) disable iff (!rst_n)
    1'b1 |=> (row2 == $past(row1)));

  // R7
  flag_driven_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|code_oe) |-> ovf_oe);

  // R8
  all_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !out_en |-> (code_oe == '0 && !ovf_oe));
endmodule

// File: tb/flash_backend_tb.sv
module flash_backend_tb;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         clk_invert = 1'b0;
  logic [255:0] therm = '0;
  logic         out_en = 1'b1;
  logic         data_off = 1'b0;
  logic [7:0]   code, code_oe;
  logic         ovf, ovf_oe;
  int vectors = 0;
  int miscompares = 0;
  bit done = 1'b0;

  flash_backend u_dut (
    .clk(clk), .rst_n(rst_n), .clk_invert(clk_invert), .therm(therm),
    .out_en(out_en), .data_off(data_off), .code(code), .ovf(ovf),
    .code_oe(code_oe), .ovf_oe(ovf_oe));

  always #10 clk = ~clk;

  logic tclk;
  assign tclk = clk ^ clk_invert;

  function automatic logic [255:0] therm_of(input int n);
    logic [255:0] w = '0;
    for (int i = 0; i < n; i++) w[i] = 1'b1;
    return w;
  endfunction

  task automatic chk(input string req, input logic [8:0] act, input logic [8:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic convert(input logic [255:0] w);
    @(posedge tclk); #1 therm = w;
    @(negedge tclk); @(posedge tclk); @(negedge tclk); #2;
  endtask

  task automatic t_reset;
    chk("R9 reset", {ovf, code}, 9'd0);
    rst_n = 1'b1;
  endtask

  task automatic t_levels;
    convert(therm_of(0));   chk("R1 zero", {ovf, code}, 9'd0);
    convert(therm_of(1));   chk("R1 one", {ovf, code}, 9'd1);
    convert(therm_of(128)); chk("R1 mid", {ovf, code}, 9'd128);
    convert(therm_of(255)); chk("R2 full scale", {ovf, code}, 9'd255);
    convert(therm_of(256)); chk("R2 overflow", {ovf, code}, 9'd511);
  endtask

  task automatic t_bubble;
    logic [255:0] w;
    w = therm_of(10); w[20] = 1'b1;
    convert(w); chk("R1 bubble", {ovf, code}, 9'd11);
    w = '0; w[255] = 1'b1;
    convert(w); chk("R2 top only", {ovf, code}, 9'd511);
  endtask

  task automatic t_pipeline;
    convert(therm_of(3));
    @(posedge tclk); #1 therm = therm_of(40);
    @(negedge tclk); #1 therm = therm_of(77);
    #1 chk("R3 previous held", {ovf, code}, 9'd3);
    @(negedge tclk); #2 chk("R3 first word", {ovf, code}, 9'd40);
    @(posedge tclk); #2 chk("R5 hold across rise", {ovf, code}, 9'd40);
    @(negedge tclk); #2 chk("R3 second word", {ovf, code}, 9'd77);
  endtask

  task automatic t_enables;
    convert(therm_of(256));
    out_en = 1'b1; data_off = 1'b0; #1;
    chk("R6 both on", {ovf_oe, code_oe}, 9'h1FF);
    data_off = 1'b1; #1;
    chk("R7 data off", {ovf_oe, code_oe}, 9'h100);
    chk("R7 flag valid", {8'd0, ovf}, 9'd1);
    out_en = 1'b0; #1;
    chk("R8 off, data_off=1", {ovf_oe, code_oe}, 9'h000);
    data_off = 1'b0; #1;
    chk("R8 off, data_off=0", {ovf_oe, code_oe}, 9'h000);
    out_en = 1'b1; data_off = 1'b1;
    convert(therm_of(256));
    chk("R7 load while count off", {ovf_oe, code_oe}, 9'h100);
    chk("R7 value behind off bits", {ovf, code}, 9'd511);
    data_off = 1'b0; #1;
    chk("R6 restored", {ovf_oe, code_oe}, 9'h1FF);
  endtask

  task automatic t_invert;
    rst_n = 1'b0; #3;
    chk("R9 async clear", {ovf, code}, 9'd0);
    @(posedge clk); #1 clk_invert = 1'b1; #3 rst_n = 1'b1;
    convert(therm_of(9));
    chk("R4 inverted convert", {ovf, code}, 9'd9);
    @(posedge clk); #1 therm = therm_of(60);
    @(posedge clk); @(negedge clk); #2 chk("R4 no change on fall", {ovf, code}, 9'd9);
    @(posedge clk); #2 chk("R4 update on rise", {ovf, code}, 9'd60);
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    #35;
    t_reset();
    t_levels();
    t_bubble();
    t_pipeline();
    t_enables();
    t_invert();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule